// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a key matrix of up to eight rows by eight columns. One side of the matrix is driven and the other side is sensed. A configuration input picks the driving side. The block steps an active level along the driven lines, one line per scan slot. It samples the sensed lines at the end of each slot and builds a 64-bit key image. The image is presented as two 32-bit status words.

Two optional filters clean the sensed data. The column filter looks at the sensed pins over a settle window inside each slot. It accepts a pin only if the pin held still for the whole window. The status filter works per key. It lets a key's reported state change only after the new state has persisted for a programmed number of whole scan frames. The pull mode sets the electrical polarity of the matrix, and it therefore also sets whether a pressed key reads as 1 or as 0.

The scan sequencer is a five-state machine:

- **ST_IDLE**: the block is disabled. Once enabled it moves to ST_DRIVE.
- **ST_DRIVE**: the current line is asserted. On the next scan tick it moves to ST_SETTLE.
- **ST_SETTLE**: the block counts settle ticks. When the last tick of the window arrives it moves to ST_CAPTURE.
- **ST_CAPTURE**: the block latches the sampled keys for this line. It then moves to ST_ADVANCE.
- **ST_ADVANCE**: the line is released and the line index steps forward, wrapping after the last active line. The block then returns to ST_DRIVE.

Dropping the enable sends every state straight back to ST_IDLE. A scan tick is produced every `TICK_DIV` clocks.

Top module: `keypad_scan`

## Requirements
- R1: While `cfg_enable` is low, every output enable is 0 in the same cycle. Every status bit also reads the released level in that cycle: 1 when `cfg_pull_up` is 1, and 0 otherwise.
- R2: While scanning with `cfg_row_drive`=1, `row_oe` has bits 0..`cfg_rows_m1` set and `col_oe` is 0. With `cfg_row_drive`=0, `col_oe` has bits 0..`cfg_cols_m1` set and `row_oe` is 0.
- R3: At most one output-enabled line carries the active level at any time. The active level is 0 in pull-up mode and 1 otherwise. All other enabled lines carry the opposite level.
- R4: The key at row r and column c sits at image bit 8*r+c. `status0` holds image bits 31:0, covering rows 0 to 3. `status1` holds bits 63:32, covering rows 4 to 7. In other words, bit n of word w is row (n>>3)+4w and column n mod 8.
- R5: A pressed key reads 0 when `cfg_pull_up`=1 and reads 1 when `cfg_pull_up`=0.
- R6: Status bits for rows above `cfg_rows_m1` or for columns above `cfg_cols_m1` always read the released level.
- R7: With `cfg_stat_filt_en`=1 and code k (0 to 7), a status bit takes a new value only after the sampled key has differed from it for 2^(k+1) consecutive scan frames. A shorter press never appears.
- R8: With `cfg_stat_filt_en`=0, the sampled key state passes to the status image within one frame.
- R9: With `cfg_col_filt_en`=1 and code k, the settle window is 2^(k+1) scan ticks. A sensed pin that changes during the window leaves its key's sampled state unchanged. A pin that stays steady is accepted.
- R10: The driven side steps through lines 0..count-1 in ascending order and wraps to line 0. Each line is held for at least one scan tick before sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Scan enable |
| cfg_pull_up | input | 1 | 1: lines idle high and a pressed key reads 0 |
| cfg_row_drive | input | 1 | 1: rows drive and columns sense; 0: the reverse |
| cfg_rows_m1 | input | 3 | Row count minus one |
| cfg_cols_m1 | input | 3 | Column count minus one |
| cfg_col_code | input | 3 | Column filter period code |
| cfg_col_filt_en | input | 1 | Column filter enable |
| cfg_stat_code | input | 3 | Status filter period code |
| cfg_stat_filt_en | input | 1 | Status filter enable |
| row_in | input | 8 | Sensed row pins |
| col_in | input | 8 | Sensed column pins |
| row_out | output | 8 | Row drive values |
| row_oe | output | 8 | Row output enables |
| col_out | output | 8 | Column drive values |
| col_oe | output | 8 | Column output enables |
| status0 | output | 32 | Key image, rows 0 to 3 |
| status1 | output | 32 | Key image, rows 4 to 7 |

## Verification
Disable can land in the same cycle as a slot capture or a frame-end filter step. After each table vector has settled, the bench drops the enable at whatever phase the scan happens to be in. It then judges, one time unit later in that same cycle, that the pins are released and that the image sits at the released level. A second overlap pairs the column filter with the status path: a key is made to chatter with a period unrelated to the tick rate. The bench then expects it never to be latched while a steady key on a neighbouring line is latched normally.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;

    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int KEYS   = LINES * LINES;
    localparam int WORD_W = KEYS / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_SETTLE,
        ST_CAPTURE,
        ST_ADVANCE
    } scan_state_e;

    // Lines 0..last set, all others clear.
    function automatic logic [LINES-1:0] span_mask(input logic [IDX_W-1:0] last);
        logic [LINES-1:0] m;
        for (int i = 0; i < LINES; i++) begin
            m[i] = (i <= int'(last));
        end
        return m;
    endfunction

endpackage

// File: rtl/kps_tick_gen.sv
module kps_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/kps_sequencer.sv
module kps_sequencer
    import keypad_scan_pkg::*;
#(
    parameter int SETTLE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tick,
    input  logic [IDX_W-1:0]    line_last,
    input  logic [SETTLE_W-1:0] settle_len,
    output scan_state_e         state,
    output logic [IDX_W-1:0]    line,
    output logic                drive_on,
    output logic                slot_start,
    output logic                settle_tick,
    output logic                capture,
    output logic                frame_end
);
    scan_state_e         nxt;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                settle_done;

    assign settle_done = (settle_cnt == settle_len - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_DRIVE;
                ST_DRIVE:   if (tick) nxt = ST_SETTLE;
                ST_SETTLE:  if (tick && settle_done) nxt = ST_CAPTURE;
                ST_CAPTURE: nxt = ST_ADVANCE;
                ST_ADVANCE: nxt = ST_DRIVE;
            endcase
        end
    end

    // slot counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line       <= '0;
            settle_cnt <= '0;
        end else if (!enable) begin
            line       <= '0;
            settle_cnt <= '0;
        end else begin
            if (state == ST_DRIVE && tick) begin
                settle_cnt <= '0;
            end else if (state == ST_SETTLE && tick && !settle_done) begin
                settle_cnt <= settle_cnt + 1'b1;
            end
            if (state == ST_ADVANCE) begin
                line <= (line >= line_last) ? '0 : line + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        drive_on    = 1'b0;
        slot_start  = 1'b0;
        settle_tick = 1'b0;
        capture     = 1'b0;
        frame_end   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DRIVE: begin
                drive_on   = 1'b1;
                slot_start = tick;
            end
            ST_SETTLE: begin
                drive_on    = 1'b1;
                settle_tick = tick;
            end
            ST_CAPTURE: begin
                drive_on = 1'b1;
                capture  = 1'b1;
            end
            ST_ADVANCE: frame_end = (line >= line_last);
        endcase
    end

endmodule

// File: rtl/kps_col_filter.sv
module kps_col_filter
    import keypad_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             slot_start,
    input  logic             settle_tick,
    input  logic [LINES-1:0] sense,
    output logic [LINES-1:0] sample,
    output logic [LINES-1:0] stable
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample <= '0;
            stable <= '1;
        end else if (clear) begin
            sample <= '0;
            stable <= '1;
        end else if (slot_start) begin
            sample <= sense;
            stable <= '1;
        end else if (settle_tick) begin
            stable <= stable & ~(sense ^ sample);
            sample <= sense;
        end
    end

endmodule

// File: rtl/kps_status_image.sv
module kps_status_image
    import keypad_scan_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pull_up,
    input  logic              row_drive,
    input  logic [IDX_W-1:0]  rows_m1,
    input  logic [IDX_W-1:0]  cols_m1,
    input  logic [IDX_W-1:0]  line,
    input  logic              capture,
    input  logic              frame_end,
    input  logic [LINES-1:0]  sample,
    input  logic [LINES-1:0]  stable,
    input  logic              col_filt_en,
    input  logic              stat_filt_en,
    input  logic [CODE_W-1:0] stat_code,
    output logic [KEYS-1:0]   image
);
    localparam int CNT_W = (2 ** CODE_W) + 1;

    logic [CNT_W-1:0] thr;
    assign thr = CNT_W'(1) << (int'(stat_code) + 1);

    for (genvar k = 0; k < KEYS; k++) begin : g_key
        localparam int R = k / LINES;
        localparam int C = k % LINES;

        logic             raw_q;
        logic             deb_q;
        logic [CNT_W-1:0] cnt_q;
        logic             hit;
        logic             sbit;
        logic             sok;
        logic             in_rng;

        always_comb begin
            hit    = capture && (row_drive ? (line == IDX_W'(R)) : (line == IDX_W'(C)));
            sbit   = row_drive ? sample[C] : sample[R];
            sok    = !col_filt_en || (row_drive ? stable[C] : stable[R]);
            in_rng = (IDX_W'(R) <= rows_m1) && (IDX_W'(C) <= cols_m1);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                raw_q <= 1'b0;
                deb_q <= 1'b0;
                cnt_q <= '0;
            end else if (!enable) begin
                raw_q <= pull_up;
                deb_q <= pull_up;
                cnt_q <= '0;
            end else begin
                if (hit && sok) begin
                    raw_q <= sbit;
                end
                if (!stat_filt_en) begin
                    deb_q <= raw_q;
                    cnt_q <= '0;
                end else if (frame_end) begin
                    if (raw_q == deb_q) begin
                        cnt_q <= '0;
                    end else if (cnt_q + 1'b1 == thr) begin
                        deb_q <= raw_q;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end

        assign image[k] = (enable && in_rng) ? deb_q : pull_up;
    end

endmodule

// File: rtl/keypad_scan.sv
module keypad_scan
    import keypad_scan_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int CODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_pull_up,
    input  logic              cfg_row_drive,
    input  logic [IDX_W-1:0]  cfg_rows_m1,
    input  logic [IDX_W-1:0]  cfg_cols_m1,
    input  logic [CODE_W-1:0] cfg_col_code,
    input  logic              cfg_col_filt_en,
    input  logic [CODE_W-1:0] cfg_stat_code,
    input  logic              cfg_stat_filt_en,
    input  logic [LINES-1:0]  row_in,
    input  logic [LINES-1:0]  col_in,
    output logic [LINES-1:0]  row_out,
    output logic [LINES-1:0]  row_oe,
    output logic [LINES-1:0]  col_out,
    output logic [LINES-1:0]  col_oe,
    output logic [WORD_W-1:0] status0,
    output logic [WORD_W-1:0] status1
);
    localparam int SETTLE_W = (2 ** CODE_W) + 1;

    logic                tick;
    scan_state_e         state;
    logic [IDX_W-1:0]    line;
    logic [IDX_W-1:0]    line_last;
    logic [SETTLE_W-1:0] settle_len;
    logic                drive_on;
    logic                slot_start;
    logic                settle_tick;
    logic                capture;
    logic                frame_end;
    logic [LINES-1:0]    sense;
    logic [LINES-1:0]    sample;
    logic [LINES-1:0]    stable;
    logic [KEYS-1:0]     image;
    logic [LINES-1:0]    drv_oe;
    logic [LINES-1:0]    drv_val;
    logic                act;

    assign line_last  = cfg_row_drive ? cfg_rows_m1 : cfg_cols_m1;
    assign settle_len = cfg_col_filt_en ? (SETTLE_W'(1) << (int'(cfg_col_code) + 1))
                                        : SETTLE_W'(1);
    assign sense      = cfg_row_drive ? col_in : row_in;

    kps_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (cfg_enable),
        .tick (tick)
    );

    kps_sequencer #(.SETTLE_W(SETTLE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .tick       (tick),
        .line_last  (line_last),
        .settle_len (settle_len),
        .state      (state),
        .line       (line),
        .drive_on   (drive_on),
        .slot_start (slot_start),
        .settle_tick(settle_tick),
        .capture    (capture),
        .frame_end  (frame_end)
    );

    kps_col_filter u_colf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!cfg_enable),
        .slot_start (slot_start),
        .settle_tick(settle_tick),
        .sense      (sense),
        .sample     (sample),
        .stable     (stable)
    );

    kps_status_image #(.CODE_W(CODE_W)) u_img (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .pull_up     (cfg_pull_up),
        .row_drive   (cfg_row_drive),
        .rows_m1     (cfg_rows_m1),
        .cols_m1     (cfg_cols_m1),
        .line        (line),
        .capture     (capture),
        .frame_end   (frame_end),
        .sample      (sample),
        .stable      (stable),
        .col_filt_en (cfg_col_filt_en),
        .stat_filt_en(cfg_stat_filt_en),
        .stat_code   (cfg_stat_code),
        .image       (image)
    );

    // pin drive: active level is low in pull-up mode
    always_comb begin
        act    = ~cfg_pull_up;
        drv_oe = (cfg_enable && state != ST_IDLE) ? span_mask(line_last) : '0;
        for (int i = 0; i < LINES; i++) begin
            drv_val[i] = (drive_on && line == IDX_W'(i)) ? act : ~act;
        end
        row_oe  = cfg_row_drive ? drv_oe : '0;
        col_oe  = cfg_row_drive ? '0 : drv_oe;
        row_out = row_oe & drv_val;
        col_out = col_oe & drv_val;
    end

    assign status0 = image[WORD_W-1:0];
    assign status1 = image[KEYS-1:WORD_W];

endmodule

// File: rtl/keypad_scan_checker.sv
module keypad_scan_checker
    import keypad_scan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              cfg_pull_up,
    input logic              cfg_row_drive,
    input logic [IDX_W-1:0]  cfg_rows_m1,
    input logic [IDX_W-1:0]  cfg_cols_m1,
    input logic [LINES-1:0]  row_out,
    input logic [LINES-1:0]  row_oe,
    input logic [LINES-1:0]  col_out,
    input logic [LINES-1:0]  col_oe,
    input logic [WORD_W-1:0] status0,
    input logic [WORD_W-1:0] status1
);
    logic [LINES-1:0] act_vec;
    logic [LINES-1:0] last_act;
    logic [LINES-1:0] any_oe;
    logic [KEYS-1:0]  img;
    logic [KEYS-1:0]  in_mask;

    always_comb begin
        act_vec = (row_oe & (cfg_pull_up ? ~row_out : row_out))
                | (col_oe & (cfg_pull_up ? ~col_out : col_out));
        any_oe  = row_oe | col_oe;
        img     = {status1, status0};
        for (int k = 0; k < KEYS; k++) begin
            in_mask[k] = ((k / LINES) <= int'(cfg_rows_m1)) && ((k % LINES) <= int'(cfg_cols_m1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_act <= '0;
        end else if (!cfg_enable) begin
            last_act <= '0;
        end else if (act_vec != '0) begin
            last_act <= act_vec;
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (row_oe == '0 && col_oe == '0)); // R1

    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (img == {KEYS{cfg_pull_up}})); // R1

    AST_SIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_row_drive ? (col_oe == '0) : (row_oe == '0)); // R2

    AST_OE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && any_oe != '0) |->
            (any_oe == span_mask(cfg_row_drive ? cfg_rows_m1 : cfg_cols_m1))); // R2

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_vec)); // R3

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && act_vec != '0 && last_act != '0 && act_vec != last_act) |->
            (act_vec == (last_act << 1) || act_vec == LINES'(1))); // R10

    AST_RANGE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ((img ^ {KEYS{cfg_pull_up}}) & ~in_mask) == '0); // R6

endmodule

bind keypad_scan keypad_scan_checker u_keypad_scan_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_pull_up  (cfg_pull_up),
    .cfg_row_drive(cfg_row_drive),
    .cfg_rows_m1  (cfg_rows_m1),
    .cfg_cols_m1  (cfg_cols_m1),
    .row_out      (row_out),
    .row_oe       (row_oe),
    .col_out      (col_out),
    .col_oe       (col_oe),
    .status0      (status0),
    .status1      (status1)
);

// File: tb/keypad_scan_bench.sv
module keypad_scan_bench;
    import keypad_scan_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        cfg_enable, cfg_pull_up, cfg_row_drive;
    logic [2:0]  cfg_rows_m1, cfg_cols_m1, cfg_col_code, cfg_stat_code;
    logic        cfg_col_filt_en, cfg_stat_filt_en;
    logic [7:0]  row_in, col_in, row_out, row_oe, col_out, col_oe;
    logic [31:0] status0, status1;
    logic [63:0] img;

    logic [63:0] keys      = '0;
    logic [63:0] chat_mask = '0;
    logic        chat_on    = 1'b0;
    logic        chat_phase = 1'b0;
    int          chat_cnt   = 0;

    int n_chk = 0;
    int n_err = 0;
    int mon_err = 0;
    logic [7:0] mon_act;
    logic [7:0] mon_last = '0;
    logic glitch_on = 1'b0;
    logic glitch_seen = 1'b0;

    keypad_scan u_keypad_scan (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_pull_up(cfg_pull_up), .cfg_row_drive(cfg_row_drive),
        .cfg_rows_m1(cfg_rows_m1), .cfg_cols_m1(cfg_cols_m1),
        .cfg_col_code(cfg_col_code), .cfg_col_filt_en(cfg_col_filt_en),
        .cfg_stat_code(cfg_stat_code), .cfg_stat_filt_en(cfg_stat_filt_en),
        .row_in(row_in), .col_in(col_in),
        .row_out(row_out), .row_oe(row_oe), .col_out(col_out), .col_oe(col_oe),
        .status0(status0), .status1(status1)
    );

    assign img = {status1, status0};

    // key matrix model: a pressed key joins its row and column
    logic        m_act;
    logic [63:0] m_eff;
    always_comb begin
        m_act  = ~cfg_pull_up;
        m_eff  = keys | ((chat_on && chat_phase) ? chat_mask : 64'd0);
        row_in = {8{~m_act}};
        col_in = {8{~m_act}};
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                if (m_eff[r*8+c]) begin
                    if (row_oe[r] && row_out[r] == m_act) col_in[c] = m_act;
                    if (col_oe[c] && col_out[c] == m_act) row_in[r] = m_act;
                end
            end
        end
    end

    // chatter source and pin monitor, away from the active edge
    always @(negedge clk) begin
        chat_cnt   <= (chat_cnt == 9) ? 0 : chat_cnt + 1;
        chat_phase <= (chat_cnt >= 4);
        mon_act = (row_oe & (cfg_pull_up ? ~row_out : row_out))
                | (col_oe & (cfg_pull_up ? ~col_out : col_out));
        if (!rst_n || !cfg_enable) begin
            mon_last = '0;
        end else begin
            if ($countones(mon_act) > 1) mon_err++;                       // R3
            if (mon_act != 0 && mon_last != 0 && mon_act != mon_last &&
                !(mon_act == (mon_last << 1) || mon_act == 8'h01)) mon_err++; // R10
            if (mon_act != 0) mon_last = mon_act;
        end
        if (glitch_on && img[19]) glitch_seen = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_image(input logic pull, input logic [2:0] rm,
                                              input logic [2:0] cm, input logic [63:0] k);
        logic [63:0] e;
        for (int idx = 0; idx < 64; idx++) begin
            e[idx] = ((idx / 8) <= int'(rm) && (idx % 8) <= int'(cm) && k[idx]) ? ~pull : pull;
        end
        return e;
    endfunction

    function automatic logic [7:0] span(input logic [2:0] last);
        return 8'((9'd1 << (int'(last) + 1)) - 9'd1);
    endfunction

    // {pull_up, row_drive, rows_m1, cols_m1, pressed keys}
    localparam logic [71:0] VEC [6] = '{
        {1'b1, 1'b1, 3'd7, 3'd7, 64'h0000_0000_0000_0001},
        {1'b0, 1'b1, 3'd7, 3'd7, 64'h8000_0000_0000_0000},
        {1'b0, 1'b0, 3'd7, 3'd7, 64'h0000_0010_0400_0080},
        {1'b1, 1'b0, 3'd3, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 1'b1, 3'd0, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 1'b1, 3'd5, 3'd4, 64'h0012_3456_789A_BCDE}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_enable = 1'b0; cfg_pull_up = 1'b1; cfg_row_drive = 1'b1;
        cfg_rows_m1 = 3'd7; cfg_cols_m1 = 3'd7;
        cfg_col_code = 3'd0; cfg_col_filt_en = 1'b0;
        cfg_stat_code = 3'd0; cfg_stat_filt_en = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset image", img, '1);
        check("R1 reset enables", {48'd0, row_oe, col_oe}, 64'd0);

        // table walk: R4 R5 R6 R8 R2 R1
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cfg_pull_up   = VEC[i][71];
            cfg_row_drive = VEC[i][70];
            cfg_rows_m1   = VEC[i][69:67];
            cfg_cols_m1   = VEC[i][66:64];
            keys          = VEC[i][63:0];
            repeat (4) @(negedge clk);
            cfg_enable = 1'b1;
            repeat (500) @(negedge clk);
            check("R4 R5 R6 R8 image", img,
                  exp_image(VEC[i][71], VEC[i][69:67], VEC[i][66:64], VEC[i][63:0]));
            check("R2 drive enables", {48'd0, row_oe, col_oe},
                  VEC[i][70] ? {48'd0, span(VEC[i][69:67]), 8'h00}
                             : {48'd0, 8'h00, span(VEC[i][66:64])});
            cfg_enable = 1'b0;
            #1;
            check("R1 disable image", img, {64{VEC[i][71]}});
            check("R1 disable enables", {48'd0, row_oe, col_oe}, 64'd0);
        end
        check("R3 R10 drive order", 64'(mon_err), 64'd0);

        // R7 status filter, code 2 = 8 frames
        @(negedge clk);
        keys = '0;
        cfg_pull_up = 1'b0; cfg_row_drive = 1'b1;
        cfg_rows_m1 = 3'd7; cfg_cols_m1 = 3'd7;
        cfg_stat_filt_en = 1'b1; cfg_stat_code = 3'd2;
        repeat (2) @(negedge clk);
        cfg_enable = 1'b1;
        repeat (300) @(negedge clk);
        glitch_on = 1'b1;
        keys[19] = 1'b1;
        repeat (150) @(negedge clk);
        keys = '0;
        repeat (400) @(negedge clk);
        glitch_on = 1'b0;
        check("R7 short press hidden", {63'd0, glitch_seen}, 64'd0);
        keys[19] = 1'b1;
        repeat (300) @(negedge clk);
        check("R7 held below period", img, 64'd0);
        repeat (1500) @(negedge clk);
        check("R7 held past period", img, 64'd1 << 19);
        cfg_enable = 1'b0;
        cfg_stat_filt_en = 1'b0;

        // R9 column filter, code 2 = 8 ticks
        @(negedge clk);
        keys = 64'h2;
        chat_mask = 64'd1 << 13;
        chat_on = 1'b1;
        cfg_rows_m1 = 3'd1;
        cfg_col_filt_en = 1'b1; cfg_col_code = 3'd2;
        repeat (2) @(negedge clk);
        cfg_enable = 1'b1;
        repeat (800) @(negedge clk);
        check("R9 chattering pin rejected", img, 64'h2);
        chat_on = 1'b0;
        keys = keys | (64'd1 << 13);
        repeat (400) @(negedge clk);
        check("R9 steady pin accepted", img, 64'h2002);
        cfg_enable = 1'b0;

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule